// File: doc/BRIEF.md
# One-Shot Thermometer Read Sequencer

This block polls a digital thermometer over a four-wire serial bus and needs no software. After reset it runs the same cycle again and again. It opens a chip-enable window and writes the one-shot command into the sensor's control register, then closes the window. It waits out the conversion time and opens a second window. In that window it sends the read address of the temperature high byte, followed by two dummy bytes. The sensor's address counter moves downward during a burst, so the first dummy byte clocks in the high byte and the second clocks in the low byte. The block then packs the signed 10-bit result, raises a one-cycle valid strobe, rests for a programmable interval and starts over.

The serial clock idles low. The controller launches data on the falling edge and samples on the rising edge, most significant bit first. The serial clock half period, the chip-enable setup and gap time, the conversion wait and the rest interval are all parameters counted in system clocks. This lets a simulation use short values while the silicon uses the roughly 200 ms figures.

Top module: `tsense_reader`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `sens_ce`, `sens_sclk` and `temp_valid` are 0 and `temp_q` is 0, including when reset lands in the middle of a window. After reset the first window opened is a command write.
- R2: `sens_sclk` is low outside a byte. Within a byte, each high phase and each low phase between rising edges lasts `HALF_CLKS` system clocks. Every window carries a whole number of 8-bit bytes, sent MSB first on `sens_mosi`.
- R3: `sens_sclk` never rises while `sens_ce` is low. `sens_ce` stays low for at least `GAP_CLKS` clocks between any two windows.
- R4: The command window carries exactly two bytes. The first is 0x80: bit 7 = 1 marks a write, and the low bits select control register 0. The second is the one-shot code 0x11.
- R5: The time from the end of the command window to the start of the next read window is at least `CONV_WAIT_CLKS` clocks.
- R6: The read window follows every command window and carries exactly three bytes: address 0x02 (bit 7 = 0 marks a read, register 2 holds the high byte), then two dummy bytes 0x00.
- R7: `temp_q` equals the high byte in bits 9..2 and bits 7..6 of the low byte in bits 1..0. This is two's complement at 0.25 °C per LSB, and bits 5..0 of the low byte have no effect on it.
- R8: `temp_valid` is high for exactly one clock per read window. `temp_q` changes only in a cycle where `temp_valid` is high.
- R9: After a read window, `sens_ce` stays low for at least `IDLE_WAIT_CLKS` clocks before the next command window opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sens_miso | input | 1 | Serial data from the sensor |
| sens_sclk | output | 1 | Serial clock, idles low |
| sens_mosi | output | 1 | Serial data to the sensor |
| sens_ce | output | 1 | Active-high sensor chip enable |
| temp_q | output | 10 | Signed temperature, 0.25 °C per LSB |
| temp_valid | output | 1 | One-cycle strobe marking a new `temp_q` |

## Verification
A sequencer stuck in the wrong state shows at the pins within one byte time. The wrong byte appears on `sens_mosi`, a window holds the wrong number of bytes, or windows come in the wrong order. An early exit from a wait state shows as a short chip-enable low time at the very next rising edge of `sens_ce`. A wrong capture or packing register shows only at the next valid strobe, as a wrong `temp_q`. For that reason the sensor model returns different junk in the low byte's unused bits on each pass.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   localparam int TEMP_W = 10;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] CTRL_WR_ADDR = 8'h80;
   localparam logic [BYTE_W-1:0] ONESHOT_CMD  = 8'h11;
   localparam logic [BYTE_W-1:0] TEMP_HI_ADDR = 8'h02;
   localparam logic [BYTE_W-1:0] DUMMY_BYTE   = 8'h00;

   typedef enum logic [3:0] {
      ST_REST,
      ST_SETUP_W,
      ST_CMD_ADDR,
      ST_CMD_DATA,
      ST_CONV,
      ST_SETUP_R,
      ST_RD_ADDR,
      ST_RD_HI,
      ST_RD_LO
   } seq_state_t;

   function automatic logic ce_active(input seq_state_t s);
      return (s == ST_SETUP_W) || (s == ST_CMD_ADDR) || (s == ST_CMD_DATA) ||
             (s == ST_SETUP_R) || (s == ST_RD_ADDR)  || (s == ST_RD_HI)    ||
             (s == ST_RD_LO);
   endfunction

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/tsr_spi_byte.sv
module tsr_spi_byte #(
   parameter int HALF_CLKS = 20,
   parameter int BYTE_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte
);

   localparam int BIT_W = $clog2(BYTE_W);

   logic              tick;
   logic [BIT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] sh_q;

   generate
      if (HALF_CLKS == 1) begin : g_nodiv
         assign tick = busy;
      end else begin : g_div
         localparam int DIV_W = $clog2(HALF_CLKS);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (!busy || tick)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
         assign tick = busy && (div_q == DIV_W'(HALF_CLKS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         done    <= 1'b0;
         bit_q   <= '0;
         sh_q    <= '0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sh_q  <= tx_byte;
            busy  <= 1'b1;
            bit_q <= '0;
         end else if (tick) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_byte <= {rx_byte[BYTE_W-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bit_q == BIT_W'(BYTE_W - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = sh_q[BYTE_W-1];

   assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   assert_sclk_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

endmodule

// File: rtl/tsr_interval_timer.sv
module tsr_interval_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   assert_reload_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/tsr_sequencer.sv
module tsr_sequencer
   import tsr_pkg::*;
#(
   parameter int CNT_W          = 8,
   parameter int GAP_CLKS       = 8,
   parameter int CONV_WAIT_CLKS = 100,
   parameter int IDLE_WAIT_CLKS = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              timer_expired,
   output logic              timer_load,
   output logic [CNT_W-1:0]  timer_val,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [BYTE_W-1:0] eng_rx,
   output logic              eng_start,
   output logic [BYTE_W-1:0] eng_tx,
   output logic              ce,
   output logic [TEMP_W-1:0] temp_q,
   output logic              temp_valid
);

   seq_state_t        state_q, state_d;
   logic              issued_q, issued_d;
   logic              byte_step;
   logic              take_hi, publish;
   logic [BYTE_W-1:0] hi_q;

   always_comb begin
      byte_step = 1'b1;
      eng_tx    = DUMMY_BYTE;
      unique case (state_q)
         ST_CMD_ADDR:        eng_tx = CTRL_WR_ADDR;
         ST_CMD_DATA:        eng_tx = ONESHOT_CMD;
         ST_RD_ADDR:         eng_tx = TEMP_HI_ADDR;
         ST_RD_HI, ST_RD_LO: eng_tx = DUMMY_BYTE;
         default:            byte_step = 1'b0;
      endcase
   end

   always_comb begin
      state_d    = state_q;
      issued_d   = issued_q;
      eng_start  = 1'b0;
      timer_load = 1'b0;
      timer_val  = '0;
      take_hi    = 1'b0;
      publish    = 1'b0;
      if (byte_step) begin
         if (!issued_q) begin
            eng_start = 1'b1;
            issued_d  = 1'b1;
         end else if (eng_done) begin
            issued_d = 1'b0;
            unique case (state_q)
               ST_CMD_ADDR: state_d = ST_CMD_DATA;
               ST_CMD_DATA: begin
                  state_d    = ST_CONV;
                  timer_load = 1'b1;
                  timer_val  = CNT_W'(CONV_WAIT_CLKS);
               end
               ST_RD_ADDR:  state_d = ST_RD_HI;
               ST_RD_HI: begin
                  state_d = ST_RD_LO;
                  take_hi = 1'b1;
               end
               default: begin
                  state_d    = ST_REST;
                  timer_load = 1'b1;
                  timer_val  = CNT_W'(IDLE_WAIT_CLKS);
                  publish    = 1'b1;
               end
            endcase
         end
      end else if (timer_expired) begin
         unique case (state_q)
            ST_REST: begin
               state_d    = ST_SETUP_W;
               timer_load = 1'b1;
               timer_val  = CNT_W'(GAP_CLKS);
            end
            ST_SETUP_W: state_d = ST_CMD_ADDR;
            ST_CONV: begin
               state_d    = ST_SETUP_R;
               timer_load = 1'b1;
               timer_val  = CNT_W'(GAP_CLKS);
            end
            default:    state_d = ST_RD_ADDR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_REST;
         issued_q   <= 1'b0;
         hi_q       <= '0;
         temp_q     <= '0;
         temp_valid <= 1'b0;
      end else begin
         state_q    <= state_d;
         issued_q   <= issued_d;
         temp_valid <= publish;
         if (take_hi) hi_q   <= eng_rx;
         if (publish) temp_q <= {hi_q, eng_rx[BYTE_W-1:BYTE_W-2]};
      end
   end

   assign ce = ce_active(state_q);

   assert_ce_held_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> ce);
   assert_conv_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV && !timer_expired) |=> (state_q == ST_CONV));
   assert_rest_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REST && !timer_expired) |=> (state_q == ST_REST));
   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      temp_valid |=> !temp_valid);
   assert_result_moves_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_q != $past(temp_q)) |-> temp_valid);
   assert_valid_outside_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      temp_valid |-> !ce);

endmodule

// File: rtl/tsense_reader.sv
module tsense_reader
   import tsr_pkg::*;
#(
   parameter int HALF_CLKS      = 20,
   parameter int GAP_CLKS       = 8,
   parameter int CONV_WAIT_CLKS = 50_000_000,
   parameter int IDLE_WAIT_CLKS = 50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sens_miso,
   output logic              sens_sclk,
   output logic              sens_mosi,
   output logic              sens_ce,
   output logic [TEMP_W-1:0] temp_q,
   output logic              temp_valid
);

   localparam int MAX_WAIT = max_of3(GAP_CLKS, CONV_WAIT_CLKS, IDLE_WAIT_CLKS);
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   initial begin
      assert (HALF_CLKS >= 1) else $error("HALF_CLKS must be at least 1");
      assert (GAP_CLKS >= 1) else $error("GAP_CLKS must be at least 1");
      assert (CONV_WAIT_CLKS >= GAP_CLKS) else $error("CONV_WAIT_CLKS below GAP_CLKS");
      assert (IDLE_WAIT_CLKS >= GAP_CLKS) else $error("IDLE_WAIT_CLKS below GAP_CLKS");
   end

   logic              t_load, t_expired;
   logic [CNT_W-1:0]  t_val;
   logic              e_start, e_busy, e_done;
   logic [BYTE_W-1:0] e_tx, e_rx;

   tsr_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   tsr_spi_byte #(.HALF_CLKS(HALF_CLKS), .BYTE_W(BYTE_W)) u_byte (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (e_start),
      .tx_byte (e_tx),
      .miso    (sens_miso),
      .sclk    (sens_sclk),
      .mosi    (sens_mosi),
      .busy    (e_busy),
      .done    (e_done),
      .rx_byte (e_rx)
   );

   tsr_sequencer #(
      .CNT_W          (CNT_W),
      .GAP_CLKS       (GAP_CLKS),
      .CONV_WAIT_CLKS (CONV_WAIT_CLKS),
      .IDLE_WAIT_CLKS (IDLE_WAIT_CLKS)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .timer_expired (t_expired),
      .timer_load    (t_load),
      .timer_val     (t_val),
      .eng_busy      (e_busy),
      .eng_done      (e_done),
      .eng_rx        (e_rx),
      .eng_start     (e_start),
      .eng_tx        (e_tx),
      .ce            (sens_ce),
      .temp_q        (temp_q),
      .temp_valid    (temp_valid)
   );

   assert_sclk_within_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sens_sclk |-> sens_ce);

endmodule

// File: tb/tsense_reader_bench.sv
`timescale 1ns/1ps
module tsense_reader_bench;

   localparam int HALF = 2;
   localparam int GAP  = 3;
   localparam int CONV = 300;
   localparam int IDLE = 150;
   localparam int NV   = 8;

   // {temp[9:0], junk in low byte bits 5..0}
   localparam logic [15:0] VEC [NV] = '{
      {10'h064, 6'b101101},   // +25.00
      {10'h3FF, 6'b111111},   // -0.25
      {10'h000, 6'b000000},   // 0
      {10'h1FF, 6'b010101},   // +127.75
      {10'h200, 6'b110011},   // -128.00
      {10'h324, 6'b100001},   // -55.00
      {10'h1F4, 6'b011110},   // +125.00
      {10'h2AA, 6'b101010}    // alternating bits
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       miso;
   logic       sclk, mosi, ce, temp_valid;
   logic [9:0] temp_q;

   always #2 clk = ~clk;

   tsense_reader #(
      .HALF_CLKS(HALF), .GAP_CLKS(GAP), .CONV_WAIT_CLKS(CONV), .IDLE_WAIT_CLKS(IDLE)
   ) u_tsense_reader (
      .clk(clk), .rst_n(rst_n), .sens_miso(miso), .sens_sclk(sclk),
      .sens_mosi(mosi), .sens_ce(ce), .temp_q(temp_q), .temp_valid(temp_valid)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // behavioural sensor and port monitor, sampled at the falling clock edge
   logic [15:0] cur_vec;
   logic [7:0]  regs [4];
   logic [7:0]  win_b [4];
   logic [7:0]  in_sr, out_sr, addr;
   logic [1:0]  ptr;
   int   bitn, nb, last_rise_ce, last_fall_ce, last_fall_sclk, last_rise_sclk;
   bit   ce_p, sclk_p, valid_p, expect_wr, prev_was_wr, have_fall, stray, tbad, stable_bad;
   logic [9:0] exp_temp, last_temp;
   int   vcount = 0;

   initial begin
      miso = 1'b0;
      for (int k = 0; k < 4; k++) regs[k] = 8'hC3;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         ce_p = 0; sclk_p = 0; valid_p = 0; expect_wr = 1; have_fall = 0;
         stray = 0; tbad = 0; stable_bad = 0; last_temp = '0; miso = 1'b0;
      end else begin
         if (sclk && !ce) stray = 1;
         if (valid_p) check(!temp_valid, "R8 strobe width", int'(temp_valid), 0);
         if (!temp_valid && temp_q != last_temp) stable_bad = 1;
         if (temp_valid) begin
            vcount++;
            check(temp_q == exp_temp, "R7 packed result", int'(temp_q), int'(exp_temp));
            check(!stable_bad, "R8 result held between strobes", int'(stable_bad), 0);
            stable_bad = 0;
            last_temp  = temp_q;
         end
         valid_p = temp_valid;

         if (ce && !ce_p) begin
            if (have_fall) begin
               check(cyc - last_fall_ce >= GAP, "R3 chip-enable gap", cyc - last_fall_ce, GAP);
               if (prev_was_wr)
                  check(cyc - last_fall_ce >= CONV, "R5 conversion wait", cyc - last_fall_ce, CONV);
               else
                  check(cyc - last_fall_ce >= IDLE, "R9 rest interval", cyc - last_fall_ce, IDLE);
            end
            last_rise_ce = cyc;
            bitn = 0; nb = 0; out_sr = '0; addr = '0; ptr = '0; miso = 1'b0;
            tbad = 0;
         end

         if (ce && sclk && !sclk_p) begin
            if (bitn % 8 != 0 && cyc - last_fall_sclk != HALF) tbad = 1;
            last_rise_sclk = cyc;
            in_sr = {in_sr[6:0], mosi};
            bitn++;
            if (bitn % 8 == 0) begin
               if (nb < 4) win_b[nb] = in_sr;
               nb++;
               if (nb == 1) begin addr = in_sr; ptr = in_sr[1:0]; end
               if (!addr[7]) begin out_sr = regs[ptr]; ptr = ptr - 2'd1; end
            end
         end
         if (!sclk && sclk_p) begin
            if (cyc - last_rise_sclk != HALF) tbad = 1;
            last_fall_sclk = cyc;
            miso   = out_sr[7];
            out_sr = {out_sr[6:0], 1'b0};
         end

         if (!ce && ce_p) begin
            check(!stray, "R3 sclk outside chip enable", int'(stray), 0);
            check(!tbad, "R2 sclk phase length", int'(tbad), 0);
            check(bitn == 8 * nb && nb > 0, "R2 whole bytes", bitn, 8 * nb);
            if (win_b[0][7]) begin
               check(expect_wr, "R4 command window order", 0, 1);
               check(nb == 2, "R4 command byte count", nb, 2);
               check(win_b[0] == 8'h80, "R4 control write address", int'(win_b[0]), 'h80);
               check(win_b[1] == 8'h11, "R4 one-shot code", int'(win_b[1]), 'h11);
               regs[2]  = cur_vec[15:8];
               regs[1]  = cur_vec[7:0];
               exp_temp = cur_vec[15:6];
               expect_wr   = 0;
               prev_was_wr = 1;
            end else begin
               check(!expect_wr, "R6 read window order", 1, 0);
               check(nb == 3, "R6 read byte count", nb, 3);
               check(win_b[0] == 8'h02, "R6 read address", int'(win_b[0]), 'h02);
               check(win_b[1] == 8'h00 && win_b[2] == 8'h00, "R6 dummy bytes",
                     int'({win_b[1], win_b[2]}), 0);
               expect_wr   = 1;
               prev_was_wr = 0;
            end
            last_fall_ce = cyc;
            have_fall    = 1;
            stray        = 0;
         end
         ce_p   = ce;
         sclk_p = sclk;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      rst_n   = 1'b0;
      cur_vec = VEC[0];
      repeat (4) @(posedge clk);
      @(negedge clk); #1;
      check(!ce && !sclk && !temp_valid && temp_q == 0, "R1 reset state",
            int'({ce, sclk, temp_valid}), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk); #1;
      check(!temp_valid && temp_q == 0, "R1 first cycle after reset", int'(temp_q), 0);

      for (int i = 0; i < NV; i++) begin
         int target;
         cur_vec = VEC[i];
         target  = vcount + 1;
         while (vcount < target) @(negedge clk);
      end

      // reset in the middle of a read window
      while (!(ce && nb >= 2 && !addr[7])) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk); #1;
      check(!ce && !sclk && !temp_valid && temp_q == 0, "R1 reset mid-window",
            int'({ce, sclk, temp_valid}), 0);
      cur_vec = VEC[5];
      @(posedge clk); #1 rst_n = 1'b1;
      begin
         int target;
         target = vcount + 1;
         while (vcount < target) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule